// File: doc/BRIEF.md
# Credit-Based Egress Shaper

This block gates when the shaped traffic classes of one egress port may be chosen by the transmission selector. Each class keeps a signed credit that changes once per clock. Credit grows by a per-cycle idle increment while the class has frames waiting and its gate is open. It shrinks by a per-cycle send decrement while a frame of that class is on the wire. A class is offered for selection whenever its credit is not negative, whatever the size of the frame at its head.

Each class has its own controller. The controller picks one of three modes every cycle: hold, accumulate or spend. Two further rules refine the modes. A queue that has emptied gives up any positive credit. A queue that has emptied while in debt keeps earning credit only until it reaches zero. A closed gate freezes the credit. Every result is clamped between a programmable ceiling and floor. The number of classes is a parameter, and the default of two covers the two shaped classes of a port, each tied to its own queue.

The increments come from outside the block. The idle increment is positive. The send decrement is the idle increment minus the port rate, both per cycle, so it is negative. Both are two's-complement values of `CREDIT_W` bits. All per-class buses are packed with class k in bits [k*CREDIT_W +: CREDIT_W].

Top module: `cbs_egress_shaper`

## Requirements
- R1: After reset, every class shows a credit of 0 and is eligible.
- R2: When a class has frames waiting, its gate is open and it is not sending, its credit rises by its idle increment on each clock.
- R3: When a class is sending, its credit changes by its send decrement on each clock. This holds whatever the state of its gate or queue.
- R4: The eligible bit of a class is 1 exactly when its current credit is zero or positive (sign bit clear), and follows the credit with no further delay.
- R5: When a class is not sending, has no frames waiting and has positive credit, its credit becomes 0 on the next clock. This holds with the gate open or closed.
- R6: When a class is not sending and its gate is closed, its credit does not change, unless R5 applies.
- R7: When a class is not sending, has no frames waiting, has negative credit and has its gate open, its credit rises by the idle increment but never above 0.
- R8: After any update, the credit is no higher than the class's ceiling and no lower than its floor.
- R9: Each class updates only from its own inputs. A class that is idle stays unchanged while another class is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_waiting | input | NUM_CLASSES | Per class: its queue holds at least one frame |
| q_sending | input | NUM_CLASSES | Per class: a frame of this class is being transmitted |
| gate_open | input | NUM_CLASSES | Per class: the time gate of its queue is open |
| idle_inc | input | NUM_CLASSES*CREDIT_W | Per class: signed credit added per cycle while earning |
| send_dec | input | NUM_CLASSES*CREDIT_W | Per class: signed credit added per cycle while sending (negative) |
| credit_hi | input | NUM_CLASSES*CREDIT_W | Per class: signed ceiling of the credit |
| credit_lo | input | NUM_CLASSES*CREDIT_W | Per class: signed floor of the credit |
| eligible | output | NUM_CLASSES | Per class: may be chosen by the transmission selector |
| credit | output | NUM_CLASSES*CREDIT_W | Per class: current signed credit |

## Verification
The assertions check several properties on every cycle. The credit is zero just after reset. A clip leaves exactly zero. A hold leaves the credit stable. Earning from debt never ends above zero. An accumulate or spend update stays within the ceiling or floor in force. Only the bench scenarios can show the actual amounts of each step. They also show that a gate closed in mid-debt holds the credit, that the ceiling and floor are reached from far away, and that one class is unaffected by activity on the other.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        CM_HOLD  = 2'd0,
        CM_ACCUM = 2'd1,
        CM_SPEND = 2'd2
    } cbs_mode_e;

    typedef struct packed {
        cbs_mode_e mode;
        logic      clip;
        logic      ceil_zero;
    } cbs_ctl_t;

    localparam cbs_ctl_t CTL_IDLE = '{mode: CM_HOLD, clip: 1'b0, ceil_zero: 1'b0};

endpackage

// File: rtl/cbs_state_ctl.sv
module cbs_state_ctl
    import cbs_pkg::*;
(
    input  logic     sending,
    input  logic     waiting,
    input  logic     gate_open,
    input  logic     credit_neg,
    input  logic     credit_pos,
    output cbs_ctl_t ctl
);

    always_comb begin
        ctl = CTL_IDLE;
        if (sending) begin
            ctl.mode = CM_SPEND;
        end else if (!waiting && credit_pos) begin
            ctl.clip = 1'b1;
        end else if (!gate_open) begin
            ctl.mode = CM_HOLD;
        end else if (waiting) begin
            ctl.mode = CM_ACCUM;
        end else if (credit_neg) begin
            ctl.mode      = CM_ACCUM;
            ctl.ceil_zero = 1'b1;
        end else begin
            ctl.mode = CM_HOLD;
        end
    end

endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
    import cbs_pkg::*;
#(
    parameter int CREDIT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  cbs_ctl_t                   ctl,
    input  logic signed [CREDIT_W-1:0] idle_inc,
    input  logic signed [CREDIT_W-1:0] send_dec,
    input  logic signed [CREDIT_W-1:0] hi_lim,
    input  logic signed [CREDIT_W-1:0] lo_lim,
    output logic signed [CREDIT_W-1:0] credit
);

    localparam int WIDE_W = CREDIT_W + 1;

    logic signed [CREDIT_W-1:0] delta;
    logic signed [WIDE_W-1:0]   sum_w;
    logic signed [WIDE_W-1:0]   hi_w;
    logic signed [WIDE_W-1:0]   lo_w;
    logic signed [WIDE_W-1:0]   clamp_w;
    logic signed [CREDIT_W-1:0] next_credit;

    always_comb begin
        delta = (ctl.mode == CM_SPEND) ? send_dec :
                (ctl.mode == CM_ACCUM) ? idle_inc : '0;
        sum_w = WIDE_W'(credit) + WIDE_W'(delta);
        hi_w  = WIDE_W'(hi_lim);
        lo_w  = WIDE_W'(lo_lim);
        if (sum_w > hi_w)
            clamp_w = hi_w;
        else if (sum_w < lo_w)
            clamp_w = lo_w;
        else
            clamp_w = sum_w;
        if (ctl.ceil_zero && clamp_w > 0)
            clamp_w = '0;
        if (ctl.clip)
            next_credit = '0;
        else if (ctl.mode == CM_HOLD)
            next_credit = credit;
        else
            next_credit = clamp_w[CREDIT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            credit <= '0;
        else
            credit <= next_credit;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> credit == '0); // R1
    AST_CLIP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.clip |=> credit == '0); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == CM_HOLD && !ctl.clip) |=> $stable(credit)); // R6
    AST_DEBT_CEIL: assert property (@(posedge clk) disable iff (rst)
        ctl.ceil_zero |=> credit <= 0); // R7
    AST_ACCUM_CEILING: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == CM_ACCUM && !ctl.clip) |=> credit <= $past(hi_lim)); // R8
    AST_SPEND_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == CM_SPEND && lo_lim <= hi_lim) |=> credit >= $past(lo_lim)); // R8

endmodule

// File: rtl/cbs_class_shaper.sv
module cbs_class_shaper
    import cbs_pkg::*;
#(
    parameter int CREDIT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       waiting,
    input  logic                       sending,
    input  logic                       gate_open,
    input  logic signed [CREDIT_W-1:0] idle_inc,
    input  logic signed [CREDIT_W-1:0] send_dec,
    input  logic signed [CREDIT_W-1:0] hi_lim,
    input  logic signed [CREDIT_W-1:0] lo_lim,
    output logic                       eligible,
    output logic signed [CREDIT_W-1:0] credit
);

    cbs_ctl_t ctl;
    logic     credit_neg;
    logic     credit_pos;

    assign credit_neg = credit[CREDIT_W-1];
    assign credit_pos = !credit[CREDIT_W-1] && (credit != '0);
    assign eligible   = !credit[CREDIT_W-1];

    cbs_state_ctl u_ctl (
        .sending    (sending),
        .waiting    (waiting),
        .gate_open  (gate_open),
        .credit_neg (credit_neg),
        .credit_pos (credit_pos),
        .ctl        (ctl)
    );

    cbs_credit_acc #(.CREDIT_W(CREDIT_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .idle_inc (idle_inc),
        .send_dec (send_dec),
        .hi_lim   (hi_lim),
        .lo_lim   (lo_lim),
        .credit   (credit)
    );

    AST_SPEND_NOT_RISING: assert property (@(posedge clk) disable iff (rst)
        (sending && send_dec < 0 && lo_lim <= credit) |=> credit <= $past(credit)); // R3

endmodule

// File: rtl/cbs_egress_shaper.sv
module cbs_egress_shaper
    import cbs_pkg::*;
#(
    parameter int NUM_CLASSES = 2,
    parameter int CREDIT_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CLASSES-1:0]          q_waiting,
    input  logic [NUM_CLASSES-1:0]          q_sending,
    input  logic [NUM_CLASSES-1:0]          gate_open,
    input  logic [NUM_CLASSES*CREDIT_W-1:0] idle_inc,
    input  logic [NUM_CLASSES*CREDIT_W-1:0] send_dec,
    input  logic [NUM_CLASSES*CREDIT_W-1:0] credit_hi,
    input  logic [NUM_CLASSES*CREDIT_W-1:0] credit_lo,
    output logic [NUM_CLASSES-1:0]          eligible,
    output logic [NUM_CLASSES*CREDIT_W-1:0] credit
);

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_class
        logic signed [CREDIT_W-1:0] cr;

        cbs_class_shaper #(.CREDIT_W(CREDIT_W)) u_cls (
            .clk       (clk),
            .rst       (rst),
            .waiting   (q_waiting[k]),
            .sending   (q_sending[k]),
            .gate_open (gate_open[k]),
            .idle_inc  (idle_inc[k*CREDIT_W +: CREDIT_W]),
            .send_dec  (send_dec[k*CREDIT_W +: CREDIT_W]),
            .hi_lim    (credit_hi[k*CREDIT_W +: CREDIT_W]),
            .lo_lim    (credit_lo[k*CREDIT_W +: CREDIT_W]),
            .eligible  (eligible[k]),
            .credit    (cr)
        );

        assign credit[k*CREDIT_W +: CREDIT_W] = cr;
    end

endmodule

// File: tb/sim_cbs_egress_shaper.sv
module sim_cbs_egress_shaper;

    localparam int NC = 2;
    localparam int W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     q_waiting = '0;
    logic [NC-1:0]     q_sending = '0;
    logic [NC-1:0]     gate_open = '0;
    logic [NC*W-1:0]   idle_inc;
    logic [NC*W-1:0]   send_dec;
    logic [NC*W-1:0]   credit_hi;
    logic [NC*W-1:0]   credit_lo;
    logic [NC-1:0]     eligible;
    logic [NC*W-1:0]   credit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cbs_egress_shaper #(.NUM_CLASSES(NC), .CREDIT_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .q_waiting (q_waiting),
        .q_sending (q_sending),
        .gate_open (gate_open),
        .idle_inc  (idle_inc),
        .send_dec  (send_dec),
        .credit_hi (credit_hi),
        .credit_lo (credit_lo),
        .eligible  (eligible),
        .credit    (credit)
    );

    // Class 0 walk: {waiting, sending, gate}, expected credit afterwards
    localparam int NV = 13;
    localparam logic [2:0] VEC_IN [0:NV-1] = '{
        3'b101, 3'b101, 3'b011, 3'b010, 3'b100, 3'b001, 3'b001,
        3'b001, 3'b001, 3'b001, 3'b101, 3'b101, 3'b001
    };
    localparam int VEC_EXP [0:NV-1] = '{
        10, 20, -10, -40, -40, -30, -20, -10, 0, 0, 10, 20, 0
    };
    localparam string VEC_REQ [0:NV-1] = '{
        "R2", "R2", "R3", "R3", "R6", "R7", "R7", "R7", "R7", "R7", "R2", "R2", "R5"
    };

    function automatic int cr_of(input int k);
        logic signed [W-1:0] v;
        v = credit[k*W +: W];
        return int'(v);
    endfunction

    task automatic check_class(input int k, input int exp_cr, input string req);
        checks++;
        if (cr_of(k) != exp_cr) begin
            errors++;
            $display("FAIL %s class%0d credit actual=%0d expected=%0d", req, k, cr_of(k), exp_cr);
        end
        checks++;
        if (eligible[k] != (exp_cr >= 0)) begin
            errors++;
            $display("FAIL R4 class%0d eligible actual=%0b expected=%0b", k, eligible[k], exp_cr >= 0);
        end
    endtask

    task automatic drive(input int k, input logic w, input logic s, input logic g);
        q_waiting[k] = w;
        q_sending[k] = s;
        gate_open[k] = g;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        idle_inc  = {16'sd7,    16'sd10};
        send_dec  = {-16'sd20,  -16'sd30};
        credit_hi = {16'sd100,  16'sd100};
        credit_lo = {-16'sd100, -16'sd100};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_class(0, 0, "R1");
        check_class(1, 0, "R1");

        // Vector walk on class 0; class 1 stays idle (R9)
        for (int i = 0; i < NV; i++) begin
            drive(0, VEC_IN[i][2], VEC_IN[i][1], VEC_IN[i][0]);
            step();
            check_class(0, VEC_EXP[i], VEC_REQ[i]);
            check_class(1, 0, "R9");
        end

        // R8: ceiling reached from zero
        drive(0, 1'b1, 1'b0, 1'b1);
        repeat (12) step();
        check_class(0, 100, "R8");
        // R8: floor reached while sending
        drive(0, 1'b1, 1'b1, 1'b1);
        repeat (10) step();
        check_class(0, -100, "R8");
        // R6: gate closed holds debt with frames waiting
        drive(0, 1'b1, 1'b0, 1'b0);
        repeat (3) step();
        check_class(0, -100, "R6");
        // R3: sending while gate closed still spends (at floor, stays at floor)
        drive(0, 1'b1, 1'b1, 1'b0);
        step();
        check_class(0, -100, "R3");
        // Earn back to positive, then clip with gate closed (R5)
        drive(0, 1'b1, 1'b0, 1'b1);
        repeat (11) step();
        check_class(0, 10, "R2");
        drive(0, 1'b0, 1'b0, 1'b0);
        step();
        check_class(0, 0, "R5");

        // Class 1: debt recovery stops at zero (R7), class 0 unaffected (R9)
        drive(1, 1'b1, 1'b1, 1'b1);
        step();
        check_class(1, -20, "R3");
        check_class(0, 0, "R9");
        drive(1, 1'b0, 1'b0, 1'b1);
        step();
        check_class(1, -13, "R7");
        step();
        check_class(1, -6, "R7");
        step();
        check_class(1, 0, "R7");
        step();
        check_class(1, 0, "R7");
        check_class(0, 0, "R9");

        // R6: gate closed, empty, negative credit holds
        drive(1, 1'b1, 1'b1, 1'b1);
        step();
        drive(1, 1'b0, 1'b0, 1'b0);
        step();
        step();
        check_class(1, -20, "R6");

        // R1: reset mid-debt returns to zero
        rst = 1'b1;
        step();
        rst = 1'b0;
        drive(1, 1'b0, 1'b0, 1'b0);
        step();
        check_class(1, 0, "R1");

        done = 1'b1;
        report();
    end

endmodule